// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

This block is a watchdog timer driven by a single control register. Writing the register sets three things: a start count, a run command and a 7-bit key. A free-running tick enable, expected at a rate of a few hundred hertz, paces the countdown. While the watchdog is armed, a write takes effect only if it carries the bitwise inverse of the key that is already stored. A runaway program that writes the same word over and over therefore cannot keep the watchdog alive or switch it off.

The watchdog escalates in two steps. When the count first runs out, the block raises a non-maskable interrupt and reloads a short grace count. If software services the watchdog with a valid write, the interrupt drops and the escalation stage clears. If the grace count also runs out, the block raises a reset request. That request stays high until the block itself is reset. The logic that acts on the reset request lies outside this block.

Top module: `wdg_keyed_top`

## Requirements
- R1: After reset, `nmi` and `rst_req` are low, the stored word is all zeros (so the watchdog is disarmed), and the counter is stopped: ticks alone never cause an expiry.
- R2: The control word is laid out as count in bits [7:0], run command in bit 8 and key in bits [15:9]. While the stored run bit is 0, a write is accepted whatever its key.
- R3: While the stored run bit is 1, a write whose key is not the bitwise inverse of the stored key is ignored. The stored word, the count in progress and the run state all stay as they were.
- R4: While the stored run bit is 1, a write whose key equals the bitwise inverse of the stored key is accepted. The word is stored and the counter reloads from the written count.
- R5: An accepted write with run bit 1 starts the countdown. An accepted write with run bit 0 stops it, so no expiry follows.
- R6: A written count of 0 loads 256. The first expiry then comes on the 256th tick.
- R7: With count N, the first expiry occurs on the N-th tick edge after the write. `nmi` goes high one cycle after that edge, and the counter reloads with GRACE_TICKS.
- R8: An expiry while `nmi` is high sets `rst_req`. It stays high through later writes until reset.
- R9: An accepted write lowers `nmi` and returns the escalation stage to the first step, so the next expiry raises `nmi` again rather than `rst_req`.
- R10: When a tick and an accepted write arrive in the same cycle, the write wins and the tick is not counted.
- R11: Cycles with `tick` low never change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 16 | Control word: key, run command, count |
| tick | input | 1 | Slow countdown enable, one cycle wide |
| nmi | output | 1 | First-stage expiry interrupt |
| rst_req | output | 1 | Second-stage expiry reset request, sticky |

## Verification
The bench targets several corner cases, each with the failure it would expose:
- **Repeated key.** A write that repeats the stored key must be ignored. A design that compared the key directly, rather than its inverse, would let that write stop the counter and suppress the interrupt.
- **Zero count.** A zero count must last 256 ticks. A design that loaded zero would never fire, or would fire at once.
- **Write and tick together.** When a write lands on a tick, the write must win. A design that let the tick through would expire one tick early.
- **Service after the interrupt.** A service write after the interrupt must return the stage to the start. A design that kept the stage would issue a reset on the next expiry instead of a second interrupt.
- **Sticky reset.** A write after the reset request must leave the request high. A design that cleared it would drop the reset.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    localparam int CNT_W  = 8;
    localparam int KEY_W  = 7;
    localparam int WORD_W = KEY_W + 1 + CNT_W;
    localparam int LOAD_W = CNT_W + 1;

    typedef struct packed {
        logic [KEY_W-1:0] key;
        logic             run;
        logic [CNT_W-1:0] count;
    } wdg_word_t;

    typedef enum logic {
        STG_ARMED  = 1'b0,
        STG_WARNED = 1'b1
    } wdg_stage_e;

    // A zero count stands for the full range 2**CNT_W.
    function automatic logic [LOAD_W-1:0] load_value(input logic [CNT_W-1:0] c);
        logic [LOAD_W-1:0] full;
        full = '0;
        full[CNT_W] = 1'b1;
        return (c == '0) ? full : {1'b0, c};
    endfunction
endpackage

// File: rtl/wdg_key_gate.sv
module wdg_key_gate
    import wdg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  wdg_word_t wr_word,
    output logic      accept,
    output wdg_word_t stored
);
    logic key_ok;

    always_comb begin
        key_ok = (wr_word.key == ~stored.key);
        accept = wr_en && (!stored.run || key_ok);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stored <= '0;
        end else if (accept) begin
            stored <= wr_word;
        end
    end

    p_ignored_keeps_word_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !accept) |=> $stable(stored));
    p_armed_needs_inverse_r4: assert property (@(posedge clk) disable iff (rst)
        (accept && stored.run) |-> (wr_word.key == ~stored.key));
endmodule

// File: rtl/wdg_tick_counter.sv
module wdg_tick_counter
    import wdg_pkg::*;
#(
    parameter int GRACE_TICKS = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_count,
    input  logic             load_run,
    input  logic             tick,
    input  logic             reload_grace,
    input  logic             halt,
    output logic             expire
);
    localparam logic [LOAD_W-1:0] GRACE_V = LOAD_W'(GRACE_TICKS);
    localparam logic [LOAD_W-1:0] ONE_V   = LOAD_W'(1);

    logic [LOAD_W-1:0] cnt;
    logic              running;

    always_comb begin
        expire = running && tick && (cnt == ONE_V) && !load;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (load) begin
            cnt     <= load_value(load_count);
            running <= load_run;
        end else if (halt) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (reload_grace) begin
            cnt <= GRACE_V;
        end else if (running && tick) begin
            cnt <= cnt - ONE_V;
        end
    end

    p_zero_is_full_r6: assert property (@(posedge clk) disable iff (rst)
        (load && load_count == '0) |=> (cnt == LOAD_W'(1 << CNT_W)));
    p_no_tick_holds_r11: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load && !halt) |=> $stable(cnt));
    p_stopped_no_expiry_r5: assert property (@(posedge clk) disable iff (rst)
        !running |-> !expire);
endmodule

// File: rtl/wdg_stage_ctl.sv
module wdg_stage_ctl
    import wdg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic expire,
    output logic reload_grace,
    output logic halt,
    output logic nmi,
    output logic rst_req
);
    wdg_stage_e stage;

    always_comb begin
        reload_grace = expire && (stage == STG_ARMED);
        halt         = expire && (stage == STG_WARNED);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage   <= STG_ARMED;
            nmi     <= 1'b0;
            rst_req <= 1'b0;
        end else if (clear) begin
            stage <= STG_ARMED;
            nmi   <= 1'b0;
        end else if (reload_grace) begin
            stage <= STG_WARNED;
            nmi   <= 1'b1;
        end else if (halt) begin
            rst_req <= 1'b1;
        end
    end

    p_rst_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> rst_req);
    p_nmi_precedes_rst_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_req) |-> $past(nmi));
    p_service_lowers_nmi_r9: assert property (@(posedge clk) disable iff (rst)
        clear |=> !nmi);
endmodule

// File: rtl/wdg_keyed_top.sv
module wdg_keyed_top
    import wdg_pkg::*;
#(
    parameter int GRACE_TICKS = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              tick,
    output logic              nmi,
    output logic              rst_req
);
    wdg_word_t wr_word;
    wdg_word_t stored;
    logic      accept;
    logic      expire;
    logic      reload_grace;
    logic      halt;

    assign wr_word = wdg_word_t'(wr_data);

    wdg_key_gate u_gate (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_word (wr_word),
        .accept  (accept),
        .stored  (stored)
    );

    wdg_tick_counter #(.GRACE_TICKS(GRACE_TICKS)) u_cnt (
        .clk          (clk),
        .rst          (rst),
        .load         (accept),
        .load_count   (wr_word.count),
        .load_run     (wr_word.run),
        .tick         (tick),
        .reload_grace (reload_grace),
        .halt         (halt),
        .expire       (expire)
    );

    wdg_stage_ctl u_stage (
        .clk          (clk),
        .rst          (rst),
        .clear        (accept),
        .expire       (expire),
        .reload_grace (reload_grace),
        .halt         (halt),
        .nmi          (nmi),
        .rst_req      (rst_req)
    );

    p_write_beats_tick_r10: assert property (@(posedge clk) disable iff (rst)
        accept |-> !expire);
endmodule

// File: tb/wdg_keyed_top_tb.sv
module wdg_keyed_top_tb;
    localparam int GR = 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        tick = 1'b0;
    logic        nmi;
    logic        rst_req;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    wdg_keyed_top #(.GRACE_TICKS(GR)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .tick(tick), .nmi(nmi), .rst_req(rst_req)
    );

    // Behavioural reference model
    logic [6:0] m_key;
    logic       m_en, m_run, m_nmi, m_rst, m_stage;
    int         m_cnt;

    always @(posedge clk) begin
        if (rst) begin
            m_key = 0; m_en = 0; m_run = 0; m_nmi = 0; m_rst = 0; m_stage = 0; m_cnt = 0;
        end else if (wr_en && (!m_en || wr_data[15:9] == ~m_key)) begin
            m_key = wr_data[15:9]; m_en = wr_data[8]; m_run = wr_data[8];
            m_cnt = (wr_data[7:0] == 0) ? 256 : int'(wr_data[7:0]);
            m_stage = 0; m_nmi = 0;
        end else if (tick && m_run) begin
            if (m_cnt == 1) begin
                if (!m_stage) begin m_stage = 1; m_nmi = 1; m_cnt = GR; end
                else begin m_rst = 1; m_run = 0; m_cnt = 0; end
            end else m_cnt = m_cnt - 1;
        end
        #1;
        checks++;
        if (nmi !== m_nmi || rst_req !== m_rst) begin
            errors++;
            $display("FAIL model R7/R8 t=%0t nmi=%b rst_req=%b expected nmi=%b rst_req=%b",
                     $time, nmi, rst_req, m_nmi, m_rst);
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] key, input logic run, input logic [7:0] cnt, input logic tk);
        @(negedge clk);
        wr_en = 1; wr_data = {key, run, cnt}; tick = tk;
        @(negedge clk);
        wr_en = 0; tick = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1;
        end
        @(negedge clk);
        tick = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog timeout");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        chk("R1 nmi after reset", nmi, 0);
        chk("R1 rst_req after reset", rst_req, 0);
        ticks(300);
        chk("R1 stopped counter no expiry", nmi, 0);

        // R2 disarmed, any key; R7 first expiry; R8 second expiry
        wr(7'h15, 1, 8'd5, 0);
        ticks(4);
        chk("R7 no nmi before N ticks", nmi, 0);
        repeat (20) @(negedge clk);
        chk("R11 idle cycles keep count", nmi, 0);
        ticks(1);
        chk("R7 nmi on N-th tick", nmi, 1);
        chk("R7 no reset yet", rst_req, 0);
        ticks(GR);
        chk("R8 rst_req after grace", rst_req, 1);
        wr(~7'h15, 1, 8'd9, 0);
        chk("R9 service lowers nmi", nmi, 0);
        chk("R8 rst_req sticky", rst_req, 1);
        do_reset();
        chk("R8 cleared by reset", rst_req, 0);

        // R3 repeated key ignored
        wr(7'h2A, 1, 8'd3, 0);
        ticks(1);
        wr(7'h2A, 0, 8'd200, 0);
        ticks(1);
        chk("R3 ignored write no nmi yet", nmi, 0);
        ticks(1);
        chk("R3 ignored write kept countdown", nmi, 1);
        // R4/R9 inverse key accepted, stage cleared
        wr(7'h55, 1, 8'd4, 0);
        chk("R9 accepted write lowers nmi", nmi, 0);
        ticks(3);
        chk("R4 reload from new count", nmi, 0);
        ticks(1);
        chk("R9 stage cleared gives nmi", nmi, 1);
        chk("R9 stage cleared no reset", rst_req, 0);
        // R5 stop
        wr(7'h2A, 0, 8'd2, 0);
        ticks(50);
        chk("R5 stopped no nmi", nmi, 0);
        chk("R5 stopped no reset", rst_req, 0);
        // R6 zero count (disarmed, any key: R2)
        wr(7'h7F, 1, 8'd0, 0);
        ticks(255);
        chk("R6 no expiry at 255", nmi, 0);
        ticks(1);
        chk("R6 expiry at 256", nmi, 1);

        // R10 write wins over same-cycle tick
        do_reset();
        wr(7'h00, 1, 8'd2, 0);
        ticks(1);
        wr(7'h7F, 1, 8'd2, 1);
        chk("R10 tick with write ignored", nmi, 0);
        ticks(1);
        chk("R10 one tick after reload", nmi, 0);
        ticks(1);
        chk("R10 expiry after full reload", nmi, 1);

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule